// File: doc/BRIEF.md
# Debug Single-Step Trace Sequencer

This block sits inside a processor debug engine and carries out one single-step request from the debug host. While the core is parked in debug mode, a one-cycle trace strobe starts a fixed hardware sequence. The sequence reports itself busy and takes the saved return address off the stack. It re-enables interrupts if they were enabled when debug mode began, then lets the core execute exactly the one instruction at that address. Once that instruction completes, the sequence freezes the core and blocks any further fetch. It then puts the address of the following instruction back on the stack, points the instruction pointer at the debug vector, turns interrupts off, halts the core and reports debug-idle again.

A debug-entry strobe moves the block from the "not in debug" state to debug-idle and records the interrupt-enable level at that moment. A debug-leave strobe takes it back out, but only from debug-idle. Because the re-pushed address is the core's next program counter, repeated trace commands step forward through the program.

Top module: `dbg_trace_seq`

## Requirements
- R1: After reset the status output is 00 (not in debug), and every request and control output is low: pop, push, IP write, IGE write, fetch supply, stall, fetch block and halt.
- R2: A debug-entry strobe while the status is 00 moves the status to 01 (debug-idle) with halt high, and latches the IGE input at that edge. Later changes of the IGE input do not alter the latched value. A debug-leave strobe while the status is 01 returns the status to 00 with halt low.
- R3: A trace strobe is ignored unless the status is 01. With status 00 the status stays 00 and no pop occurs. During a running trace, further trace or leave strobes leave the sequence unchanged.
- R4: In the cycle after an accepted trace strobe, the status is 10 (debug-busy), halt stays high, and no pop, push, IP write, IGE write or fetch is issued.
- R5: In the second busy cycle a pop is requested, and the pop data of that cycle is taken as the return address.
- R6: In the third busy cycle IGE is written with 1 if the latched entry value is 1. If the latched value is 0, no IGE write occurs.
- R7: In the fourth cycle the core is released: halt is low, the fetch-supply output is high and the fetch address equals the popped return address. This state holds until the instruction-complete input is seen high, and the core's next-PC input is captured at that edge.
- R8: In the cycle after completion, stall and fetch block are high and no push is issued yet. In the following cycle a push is requested with the captured next-PC as data, while stall and fetch block stay high.
- R9: After the push, the IP is written with the debug vector 8010h for one cycle. In the next cycle IGE is written with 0. In the cycle after that, halt is high with fetch block still high and status still 10. In the cycle after that, the status is 01.
- R10: Each pop, push, IP write and IGE write request is high for exactly one cycle per trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_enter_i | input | 1 | Debug-mode entry strobe |
| dbg_leave_i | input | 1 | Debug-mode exit strobe |
| trace_cmd_i | input | 1 | Host single-step strobe |
| status_o | output | 2 | 00 not in debug, 01 debug-idle, 10 debug-busy |
| stk_pop_o | output | 1 | Stack pop request |
| stk_pop_data_i | input | AW | Data returned by the pop |
| stk_push_o | output | 1 | Stack push request |
| stk_push_data_o | output | AW | Data to push |
| ip_we_o | output | 1 | Instruction pointer write enable |
| ip_wdata_o | output | AW | Instruction pointer write value |
| ige_i | input | 1 | Current interrupt global enable |
| ige_we_o | output | 1 | IGE write enable |
| ige_wdata_o | output | 1 | IGE write value |
| fetch_valid_o | output | 1 | Supply the instruction at fetch_addr_o to the core |
| fetch_addr_o | output | AW | Address of the single traced instruction |
| insn_done_i | input | 1 | Core finished the traced instruction |
| next_pc_i | input | AW | Core program counter after that instruction |
| cpu_stall_o | output | 1 | Stall the core |
| fetch_block_o | output | 1 | Block program-memory fetch |
| cpu_halt_o | output | 1 | Halt the core |

## Verification
The sequence is swept over both latched interrupt-enable levels, because those two settings separate a restored IGE write from a suppressed one. Each setting is run with instruction latencies of zero to three cycles, which shows that the execute phase waits for the completion pulse rather than for a fixed count. Each case is run once with clean strobes and once with trace and leave strobes held during the busy phase, which tells a sequence that ignores them from one that restarts or exits. The bench changes the pop data and next-PC inputs right after their capture edges, so that a latched address can be told apart from a live one. Back-to-back traces confirm that the pushed address moves forward.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_BUSY,
        ST_POP,
        ST_IGE,
        ST_EXEC,
        ST_STALL,
        ST_PUSH,
        ST_IPLD,
        ST_IGECLR,
        ST_HALT
    } dts_state_e;

    localparam logic [1:0] STAT_OFF  = 2'b00;
    localparam logic [1:0] STAT_IDLE = 2'b01;
    localparam logic [1:0] STAT_BUSY = 2'b10;

    typedef struct packed {
        dts_state_e st;
    } dts_ctrl_t;

endpackage

// File: rtl/dts_ctrl.sv
module dts_ctrl
    import dts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_i,
    input  logic       leave_i,
    input  logic       trace_i,
    input  logic       done_i,
    input  logic       saved_ige_i,
    output logic       enter_ack_o,
    output logic [1:0] status_o,
    output logic       pop_o,
    output logic       push_o,
    output logic       ip_we_o,
    output logic       ige_we_o,
    output logic       ige_val_o,
    output logic       exec_o,
    output logic       stall_o,
    output logic       block_o,
    output logic       halt_o
);

    dts_ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_OFF:    if (enter_i) r_d.st = ST_IDLE;
            ST_IDLE: begin
                if (trace_i)      r_d.st = ST_BUSY;
                else if (leave_i) r_d.st = ST_OFF;
            end
            ST_BUSY:   r_d.st = ST_POP;
            ST_POP:    r_d.st = ST_IGE;
            ST_IGE:    r_d.st = ST_EXEC;
            ST_EXEC:   if (done_i) r_d.st = ST_STALL;
            ST_STALL:  r_d.st = ST_PUSH;
            ST_PUSH:   r_d.st = ST_IPLD;
            ST_IPLD:   r_d.st = ST_IGECLR;
            ST_IGECLR: r_d.st = ST_HALT;
            ST_HALT:   r_d.st = ST_IDLE;
            default:   r_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_OFF};
        else        r_q <= r_d;
    end

    always_comb begin
        enter_ack_o = (r_q.st == ST_OFF) && enter_i;
        case (r_q.st)
            ST_OFF:  status_o = STAT_OFF;
            ST_IDLE: status_o = STAT_IDLE;
            default: status_o = STAT_BUSY;
        endcase
        pop_o     = (r_q.st == ST_POP);
        push_o    = (r_q.st == ST_PUSH);
        ip_we_o   = (r_q.st == ST_IPLD);
        ige_we_o  = ((r_q.st == ST_IGE) && saved_ige_i) || (r_q.st == ST_IGECLR);
        ige_val_o = (r_q.st == ST_IGE);
        exec_o    = (r_q.st == ST_EXEC);
        stall_o   = (r_q.st == ST_STALL) || (r_q.st == ST_PUSH) ||
                    (r_q.st == ST_IPLD)  || (r_q.st == ST_IGECLR);
        block_o   = stall_o || (r_q.st == ST_HALT);
        halt_o    = (r_q.st == ST_IDLE) || (r_q.st == ST_BUSY) ||
                    (r_q.st == ST_POP)  || (r_q.st == ST_IGE)  ||
                    (r_q.st == ST_HALT);
    end

    a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == STAT_IDLE && trace_i) |=> (status_o == STAT_BUSY && !pop_o && !ige_we_o));

    a_r3_off_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == STAT_OFF && !enter_i) |=> (status_o == STAT_OFF));

    a_r10_pop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> !pop_o);

    a_r10_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);

    a_r8_push_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(stall_o));

    a_r9_ige_clear_after_ip: assert property (@(posedge clk) disable iff (!rst_n)
        ip_we_o |=> (ige_we_o && !ige_val_o));

    a_r7_exec_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && !done_i) |=> exec_o);

endmodule

// File: rtl/dts_data.sv
module dts_data #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_enter_i,
    input  logic          ige_i,
    input  logic          cap_pop_i,
    input  logic [AW-1:0] pop_data_i,
    input  logic          cap_done_i,
    input  logic [AW-1:0] next_pc_i,
    output logic [AW-1:0] ret_o,
    output logic          saved_ige_o
);

    typedef struct packed {
        logic [AW-1:0] ret;
        logic          sige;
    } data_t;

    data_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap_enter_i) r_d.sige = ige_i;
        if (cap_pop_i)   r_d.ret  = pop_data_i;
        if (cap_done_i)  r_d.ret  = next_pc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ret_o       = r_q.ret;
    assign saved_ige_o = r_q.sige;

    a_r2_saved_ige_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_enter_i |=> $stable(saved_ige_o));

endmodule

// File: rtl/dbg_trace_seq.sv
module dbg_trace_seq #(
    parameter int          AW      = 16,
    parameter logic [AW-1:0] DBG_VEC = 16'h8010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_enter_i,
    input  logic          dbg_leave_i,
    input  logic          trace_cmd_i,
    output logic [1:0]    status_o,
    output logic          stk_pop_o,
    input  logic [AW-1:0] stk_pop_data_i,
    output logic          stk_push_o,
    output logic [AW-1:0] stk_push_data_o,
    output logic          ip_we_o,
    output logic [AW-1:0] ip_wdata_o,
    input  logic          ige_i,
    output logic          ige_we_o,
    output logic          ige_wdata_o,
    output logic          fetch_valid_o,
    output logic [AW-1:0] fetch_addr_o,
    input  logic          insn_done_i,
    input  logic [AW-1:0] next_pc_i,
    output logic          cpu_stall_o,
    output logic          fetch_block_o,
    output logic          cpu_halt_o
);

    logic          enter_ack;
    logic          saved_ige;
    logic [AW-1:0] ret_addr;

    dts_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (dbg_enter_i),
        .leave_i     (dbg_leave_i),
        .trace_i     (trace_cmd_i),
        .done_i      (insn_done_i),
        .saved_ige_i (saved_ige),
        .enter_ack_o (enter_ack),
        .status_o    (status_o),
        .pop_o       (stk_pop_o),
        .push_o      (stk_push_o),
        .ip_we_o     (ip_we_o),
        .ige_we_o    (ige_we_o),
        .ige_val_o   (ige_wdata_o),
        .exec_o      (fetch_valid_o),
        .stall_o     (cpu_stall_o),
        .block_o     (fetch_block_o),
        .halt_o      (cpu_halt_o)
    );

    dts_data #(.AW(AW)) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_enter_i (enter_ack),
        .ige_i       (ige_i),
        .cap_pop_i   (stk_pop_o),
        .pop_data_i  (stk_pop_data_i),
        .cap_done_i  (fetch_valid_o && insn_done_i),
        .next_pc_i   (next_pc_i),
        .ret_o       (ret_addr),
        .saved_ige_o (saved_ige)
    );

    assign stk_push_data_o = ret_addr;
    assign fetch_addr_o    = ret_addr;
    assign ip_wdata_o      = DBG_VEC;

endmodule

// File: tb/dbg_trace_seq_test.sv
module dbg_trace_seq_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dbg_enter_i, dbg_leave_i, trace_cmd_i;
    logic [1:0]    status_o;
    logic          stk_pop_o, stk_push_o, ip_we_o, ige_we_o, ige_wdata_o;
    logic [AW-1:0] stk_pop_data_i, stk_push_data_o, ip_wdata_o, fetch_addr_o, next_pc_i;
    logic          ige_i, fetch_valid_o, insn_done_i, cpu_stall_o, fetch_block_o, cpu_halt_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dbg_trace_seq #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .dbg_enter_i(dbg_enter_i), .dbg_leave_i(dbg_leave_i), .trace_cmd_i(trace_cmd_i),
        .status_o(status_o),
        .stk_pop_o(stk_pop_o), .stk_pop_data_i(stk_pop_data_i),
        .stk_push_o(stk_push_o), .stk_push_data_o(stk_push_data_o),
        .ip_we_o(ip_we_o), .ip_wdata_o(ip_wdata_o),
        .ige_i(ige_i), .ige_we_o(ige_we_o), .ige_wdata_o(ige_wdata_o),
        .fetch_valid_o(fetch_valid_o), .fetch_addr_o(fetch_addr_o),
        .insn_done_i(insn_done_i), .next_pc_i(next_pc_i),
        .cpu_stall_o(cpu_stall_o), .fetch_block_o(fetch_block_o), .cpu_halt_o(cpu_halt_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic enter_dbg(input logic ige);
        dbg_enter_i = 1'b1;
        ige_i       = ige;
        @(negedge clk);
        dbg_enter_i = 1'b0;
        ige_i       = ~ige;
        chk("R2 status after entry", 32'(status_o), 32'h1);
        chk("R2 halt after entry", 32'(cpu_halt_o), 32'h1);
    endtask

    task automatic leave_dbg();
        dbg_leave_i = 1'b1;
        @(negedge clk);
        dbg_leave_i = 1'b0;
        chk("R2 status after leave", 32'(status_o), 32'h0);
        chk("R2 halt after leave", 32'(cpu_halt_o), 32'h0);
    endtask

    task automatic do_trace(input logic ige, input int lat, input logic [AW-1:0] ret,
                            input logic [AW-1:0] npc, input logic hold);
        stk_pop_data_i = ret;
        trace_cmd_i    = 1'b1;
        @(negedge clk);
        if (!hold) trace_cmd_i = 1'b0;
        else       dbg_leave_i = 1'b1;
        chk("R4 busy status", 32'(status_o), 32'h2);
        chk("R4 no pop yet", 32'(stk_pop_o), 32'h0);
        chk("R4 no ige write", 32'(ige_we_o), 32'h0);
        chk("R4 halt held", 32'(cpu_halt_o), 32'h1);
        chk("R4 no fetch", 32'(fetch_valid_o), 32'h0);
        @(negedge clk);
        chk("R5 pop request", 32'(stk_pop_o), 32'h1);
        chk("R3 still busy", 32'(status_o), 32'h2);
        @(negedge clk);
        stk_pop_data_i = ~ret;
        chk("R10 pop single cycle", 32'(stk_pop_o), 32'h0);
        chk("R6 ige restore write", 32'(ige_we_o), 32'(ige));
        if (ige) chk("R6 ige restore value", 32'(ige_wdata_o), 32'h1);
        @(negedge clk);
        trace_cmd_i = 1'b0;
        dbg_leave_i = 1'b0;
        chk("R7 fetch supplied", 32'(fetch_valid_o), 32'h1);
        chk("R5 R7 fetch address", 32'(fetch_addr_o), 32'(ret));
        chk("R7 halt released", 32'(cpu_halt_o), 32'h0);
        chk("R3 busy ignores strobes", 32'(status_o), 32'h2);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R7 waits for done", 32'(fetch_valid_o), 32'h1);
            chk("R7 no stall while waiting", 32'(cpu_stall_o), 32'h0);
        end
        insn_done_i = 1'b1;
        next_pc_i   = npc;
        @(negedge clk);
        insn_done_i = 1'b0;
        next_pc_i   = ~npc;
        chk("R8 stall", 32'(cpu_stall_o), 32'h1);
        chk("R8 fetch block", 32'(fetch_block_o), 32'h1);
        chk("R8 no push yet", 32'(stk_push_o), 32'h0);
        chk("R8 fetch ended", 32'(fetch_valid_o), 32'h0);
        @(negedge clk);
        chk("R8 push request", 32'(stk_push_o), 32'h1);
        chk("R8 push data", 32'(stk_push_data_o), 32'(npc));
        chk("R8 stall in push", 32'(cpu_stall_o), 32'h1);
        @(negedge clk);
        chk("R10 push single cycle", 32'(stk_push_o), 32'h0);
        chk("R9 ip write", 32'(ip_we_o), 32'h1);
        chk("R9 ip vector", 32'(ip_wdata_o), 32'h8010);
        chk("R9 no ige write with ip", 32'(ige_we_o), 32'h0);
        @(negedge clk);
        chk("R10 ip single cycle", 32'(ip_we_o), 32'h0);
        chk("R9 ige clear write", 32'(ige_we_o), 32'h1);
        chk("R9 ige clear value", 32'(ige_wdata_o), 32'h0);
        @(negedge clk);
        chk("R10 ige write single cycle", 32'(ige_we_o), 32'h0);
        chk("R9 halt", 32'(cpu_halt_o), 32'h1);
        chk("R9 block at halt", 32'(fetch_block_o), 32'h1);
        chk("R9 stall released", 32'(cpu_stall_o), 32'h0);
        chk("R9 still busy", 32'(status_o), 32'h2);
        @(negedge clk);
        chk("R9 idle again", 32'(status_o), 32'h1);
        chk("R9 halt kept", 32'(cpu_halt_o), 32'h1);
        chk("R9 block dropped", 32'(fetch_block_o), 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        dbg_enter_i = 0; dbg_leave_i = 0; trace_cmd_i = 0;
        stk_pop_data_i = '0; next_pc_i = '0; ige_i = 0; insn_done_i = 0;
        repeat (3) @(negedge clk);
        chk("R1 status", 32'(status_o), 32'h0);
        chk("R1 strobes", 32'({stk_pop_o, stk_push_o, ip_we_o, ige_we_o, fetch_valid_o}), 32'h0);
        chk("R1 core controls", 32'({cpu_stall_o, fetch_block_o, cpu_halt_o}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after release", 32'(status_o), 32'h0);

        trace_cmd_i = 1'b1;
        @(negedge clk);
        trace_cmd_i = 1'b0;
        chk("R3 trace ignored when off", 32'(status_o), 32'h0);
        @(negedge clk);
        chk("R3 no pop when off", 32'(stk_pop_o), 32'h0);
        chk("R3 still off", 32'(status_o), 32'h0);

        for (int g = 0; g < 2; g++)
            for (int lat = 0; lat < 4; lat++)
                for (int h = 0; h < 2; h++) begin
                    logic [AW-1:0] ra;
                    ra = AW'(16'h0100 + (g * 8 + lat * 2 + h) * 17);
                    enter_dbg(g[0]);
                    do_trace(g[0], lat, ra, ra + AW'(1 + lat), h[0]);
                    leave_dbg();
                end

        enter_dbg(1'b1);
        do_trace(1'b1, 1, 16'h2000, 16'h2001, 1'b0);
        do_trace(1'b1, 0, 16'h2001, 16'h2003, 1'b0);
        leave_dbg();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule